// File: doc/BRIEF.md
# Partial-Flag Offset Register Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Master reset sets both offsets to a default value and fixes which programming path the block accepts. A configuration strobe `ld` chosen during master reset picks that default and path. A low `ld` gives 127 and the parallel path. A high `ld` gives 1023 and the serial path.

After reset, the write-clock side accepts new offsets. On the parallel path, each `ld` with `wen` takes one word from `din`. On the serial path, each `ld` with `sen` takes one bit from `si`, least significant bit first. The empty offset is always loaded first and the full offset second.

A write-side state machine steps between two states, WSEL_EMPTY and WSEL_FULL. It takes the transition ADVANCE after each completed register load. A read-side state machine steps between RSEL_EMPTY and RSEL_FULL. It takes the transition ADVANCE after each readback, which is a read-clock edge with `ld` and `ren` high that copies the selected offset onto `rd_q`. Both machines take the transition RETURN back to their EMPTY state on master or partial reset. Partial reset keeps the offset values and the chosen path. While `ld` is high, the FIFO write and read strobes the block passes on are held low.

Top module: `ofs_loader`

## Requirements
- R1: Master reset with `ld` low sets both offsets to 127 and selects the parallel path.
- R2: Master reset with `ld` high sets both offsets to 1023 and selects the serial path. The path stays fixed until the next master reset.
- R3: On the parallel path, a rising `wclk` edge with `ld` and `wen` high loads `din[OFS_W-1:0]` into the selected offset. The edges alternate between the empty offset and the full offset, and the empty offset comes first.
- R4: On the serial path, each rising `wclk` edge with `ld` and `sen` high shifts `si` into the selected offset at its MSB, and the register moves right. After OFS_W bits, sent LSB first, the selection moves to the other offset. The empty offset is loaded first.
- R5: `sen` has no effect on the parallel path. `ld` with `wen` has no effect on the offsets on the serial path.
- R6: A rising `rclk` edge with `ld` and `ren` high drives `rd_q` with the selected offset, zero-extended. Readbacks alternate between the empty offset and the full offset, and the empty offset comes first. At any other time `rd_q` holds its value.
- R7: Partial reset leaves both offsets and the selected path unchanged. It returns both selections to the empty offset and discards a partly shifted serial load.
- R8: `fifo_wr_en` equals `wen` while `ld` is low and is 0 while `ld` is high. `fifo_rd_en` equals `ren` while `ld` is low and is 0 while `ld` is high.
- R9: With `ld` low, `wen`, `sen` and `si` do not change either offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrs_n | input | 1 | Master reset, active low, synchronous to each clock |
| prs_n | input | 1 | Partial reset, active low, synchronous to each clock |
| ld | input | 1 | Offset access strobe; selects the default during master reset |
| wen | input | 1 | Write enable (parallel offset load while `ld` is high) |
| sen | input | 1 | Serial load enable |
| si | input | 1 | Serial offset bit |
| din | input | DATA_W | Parallel offset word |
| ren | input | 1 | Read enable (offset readback while `ld` is high) |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |
| rd_q | output | DATA_W | Readback data |
| fifo_wr_en | output | 1 | Write strobe passed on to FIFO storage |
| fifo_rd_en | output | 1 | Read strobe passed on to FIFO storage |

## Verification
The bench loads offsets with values that differ in many bit positions. On the parallel path it uses 300 then 700, and on the serial path 0x2A5 then 0x0F3. A wrong order, a wrong bit order or a stuck selection therefore gives a visibly different register.

It also tries each load path while the other path is selected. It tries strobes with `ld` low, which tells the block's gating apart from plain loading. A partial reset is applied after a single parallel load and again in the middle of a serial load, so a selection or bit count that survives the partial reset shows up in the next value loaded. Readbacks are interleaved with quiet read-clock cycles, which separates alternating readback from `rd_q` that simply follows an offset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    typedef enum logic {WSEL_EMPTY = 1'b0, WSEL_FULL = 1'b1} wsel_t;
    typedef enum logic {RSEL_EMPTY = 1'b0, RSEL_FULL = 1'b1} rsel_t;
endpackage

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 12,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic              wclk,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              ld,
    input  logic              wen,
    input  logic              sen,
    input  logic              si,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);
    localparam int CNT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [OFS_W-1:0] LO_V = OFS_W'(DEF_LO);
    localparam logic [OFS_W-1:0] HI_V = OFS_W'(DEF_HI);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OFS_W - 1);

    wsel_t            state, state_nx;
    logic             ser_mode;
    logic [CNT_W-1:0] bitcnt;
    logic             par_hit, ser_hit, bit_last, advance;

    assign par_hit  = ld && wen && !ser_mode;
    assign ser_hit  = ld && sen && ser_mode;
    assign bit_last = (bitcnt == LAST_BIT);
    assign advance  = par_hit || (ser_hit && bit_last);

    always_comb begin
        state_nx = state;
        unique case (state)
            WSEL_EMPTY: if (advance) state_nx = WSEL_FULL;
            WSEL_FULL:  if (advance) state_nx = WSEL_EMPTY;
        endcase
    end

    // state register: RETURN on either reset, ADVANCE on a completed load
    always_ff @(posedge wclk) begin
        if (!mrs_n || !prs_n) state <= WSEL_EMPTY;
        else                  state <= state_nx;
    end

    // offsets, path select and serial bit count
    always_ff @(posedge wclk) begin
        if (!mrs_n) begin
            ser_mode  <= ld;
            empty_ofs <= ld ? HI_V : LO_V;
            full_ofs  <= ld ? HI_V : LO_V;
            bitcnt    <= '0;
        end else if (!prs_n) begin
            bitcnt <= '0;
        end else if (par_hit) begin
            if (state == WSEL_EMPTY) empty_ofs <= din[OFS_W-1:0];
            else                     full_ofs  <= din[OFS_W-1:0];
        end else if (ser_hit) begin
            if (state == WSEL_EMPTY) empty_ofs <= {si, empty_ofs[OFS_W-1:1]};
            else                     full_ofs  <= {si, full_ofs[OFS_W-1:1]};
            bitcnt <= bit_last ? '0 : bitcnt + 1'b1;
        end
    end

    p_mode_fixed_r2: assert property (@(posedge wclk) disable iff (!mrs_n)
        mrs_n |=> $stable(ser_mode));

    p_par_empty_r3: assert property (@(posedge wclk) disable iff (!mrs_n)
        (prs_n && ld && wen && !ser_mode && state == WSEL_EMPTY)
        |=> (empty_ofs == $past(din[OFS_W-1:0])) && (state == WSEL_FULL));

    p_partial_keeps_r7: assert property (@(posedge wclk) disable iff (!mrs_n)
        !prs_n |=> $stable(empty_ofs) && $stable(full_ofs) && state == WSEL_EMPTY);

    p_idle_hold_r9: assert property (@(posedge wclk) disable iff (!mrs_n)
        (prs_n && !ld) |=> $stable(empty_ofs) && $stable(full_ofs));
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 12
) (
    input  logic              rclk,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              ld,
    input  logic              ren,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rd_q
);
    rsel_t rstate, rstate_nx;
    logic  rb_hit;

    assign rb_hit = ld && ren;

    always_comb begin
        rstate_nx = rstate;
        unique case (rstate)
            RSEL_EMPTY: if (rb_hit) rstate_nx = RSEL_FULL;
            RSEL_FULL:  if (rb_hit) rstate_nx = RSEL_EMPTY;
        endcase
    end

    always_ff @(posedge rclk) begin
        if (!mrs_n || !prs_n) rstate <= RSEL_EMPTY;
        else                  rstate <= rstate_nx;
    end

    always_ff @(posedge rclk) begin
        if (!mrs_n || !prs_n) rd_q <= '0;
        else if (rb_hit)      rd_q <= (rstate == RSEL_EMPTY) ? DATA_W'(empty_ofs)
                                                             : DATA_W'(full_ofs);
    end

    p_rd_hold_r6: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        !(ld && ren) |=> $stable(rd_q));

    p_rd_steps_r6: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        (ld && ren) |=> rstate != $past(rstate));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 12,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrs_n,
    input  logic              prs_n,
    input  logic              ld,
    input  logic              wen,
    input  logic              sen,
    input  logic              si,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rd_q,
    output logic              fifo_wr_en,
    output logic              fifo_rd_en
);
    ofs_wr_ctrl #(
        .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_wr (
        .wclk(wclk), .mrs_n(mrs_n), .prs_n(prs_n), .ld(ld), .wen(wen),
        .sen(sen), .si(si), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    ofs_rd_port #(
        .OFS_W(OFS_W), .DATA_W(DATA_W)
    ) u_rd (
        .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n), .ld(ld), .ren(ren),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_q(rd_q)
    );

    // offset access owns the strobes while ld is high
    assign fifo_wr_en = wen && !ld;
    assign fifo_rd_en = ren && !ld;

    p_strobe_gate_r8: assert property (@(posedge wclk) disable iff (!mrs_n)
        !(fifo_wr_en && fifo_rd_en && ld));
endmodule

// File: tb/ofs_loader_test.sv
module ofs_loader_test;
    localparam int OFS_W  = 10;
    localparam int DATA_W = 12;

    logic              wclk = 1'b0, rclk = 1'b0;
    logic              mrs_n = 1'b0, prs_n = 1'b1, ld = 1'b0;
    logic              wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [OFS_W-1:0]  empty_ofs, full_ofs;
    logic [DATA_W-1:0] rd_q;
    logic              fifo_wr_en, fifo_rd_en;

    int total = 0, fails = 0;

    ofs_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) uut (
        .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n), .ld(ld),
        .wen(wen), .sen(sen), .si(si), .din(din), .ren(ren),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_q(rd_q),
        .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
    );

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic sel);
        @(negedge wclk);
        mrs_n = 1'b0; ld = sel;
        repeat (2) @(negedge wclk);
        mrs_n = 1'b1; ld = 1'b0;
        @(negedge wclk);
    endtask

    task automatic partial_reset();
        @(negedge wclk);
        prs_n = 1'b0;
        repeat (2) @(negedge wclk);
        prs_n = 1'b1;
        @(negedge wclk);
    endtask

    task automatic par_load(input int v);
        @(negedge wclk);
        ld = 1'b1; wen = 1'b1; din = DATA_W'(v);
        #1 chk("R8 wr strobe gated", int'(fifo_wr_en), 0);
        @(negedge wclk);
        ld = 1'b0; wen = 1'b0;
    endtask

    task automatic ser_bits(input int v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            ld = 1'b1; sen = 1'b1; si = v[i];
        end
        @(negedge wclk);
        ld = 1'b0; sen = 1'b0; si = 1'b0;
    endtask

    task automatic readback(input string req, input int exp);
        @(negedge wclk);
        ld = 1'b1; ren = 1'b1;
        #1 chk("R8 rd strobe gated", int'(fifo_rd_en), 0);
        @(negedge wclk);
        chk(req, int'(rd_q), exp);
        ld = 1'b0; ren = 1'b0;
    endtask

    task automatic t_parallel_defaults();
        master_reset(1'b0);
        chk("R1 empty default", int'(empty_ofs), 127);
        chk("R1 full default", int'(full_ofs), 127);
        chk("R6 rd_q after reset", int'(rd_q), 0);
        ser_bits(10'h3FF, OFS_W);
        chk("R5 sen ignored on parallel path", int'(empty_ofs), 127);
        par_load(300);
        chk("R3 empty loaded first", int'(empty_ofs), 300);
        chk("R3 full untouched", int'(full_ofs), 127);
        par_load(700);
        chk("R3 full loaded second", int'(full_ofs), 700);
        chk("R3 empty kept", int'(empty_ofs), 300);
    endtask

    task automatic t_readback();
        readback("R6 first readback empty", 300);
        repeat (3) @(negedge wclk);
        chk("R6 rd_q holds", int'(rd_q), 300);
        readback("R6 second readback full", 700);
        readback("R6 third readback wraps", 300);
    endtask

    task automatic t_idle_strobes();
        @(negedge wclk);
        wen = 1'b1; sen = 1'b1; si = 1'b1; ren = 1'b1; din = 12'h0AB;
        #1 chk("R8 wr strobe passes", int'(fifo_wr_en), 1);
        chk("R8 rd strobe passes", int'(fifo_rd_en), 1);
        repeat (2) @(negedge wclk);
        chk("R9 empty unchanged with ld low", int'(empty_ofs), 300);
        chk("R9 full unchanged with ld low", int'(full_ofs), 700);
        chk("R6 no readback with ld low", int'(rd_q), 300);
        wen = 1'b0; sen = 1'b0; si = 1'b0; ren = 1'b0;
    endtask

    task automatic t_partial_parallel();
        par_load(5);
        partial_reset();
        chk("R7 empty kept over partial reset", int'(empty_ofs), 5);
        chk("R7 full kept over partial reset", int'(full_ofs), 700);
        par_load(9);
        chk("R7 select back on empty", int'(empty_ofs), 9);
        chk("R7 full still kept", int'(full_ofs), 700);
        readback("R7 read select back on empty", 9);
    endtask

    task automatic t_serial();
        master_reset(1'b1);
        chk("R2 empty default", int'(empty_ofs), 1023);
        chk("R2 full default", int'(full_ofs), 1023);
        par_load(77);
        chk("R5 wen load ignored on serial path", int'(empty_ofs), 1023);
        ser_bits(10'h2A5, OFS_W);
        chk("R4 empty shifted in first", int'(empty_ofs), 'h2A5);
        chk("R4 full untouched", int'(full_ofs), 1023);
        ser_bits(10'h0F3, OFS_W);
        chk("R4 full shifted in second", int'(full_ofs), 'h0F3);
        chk("R4 empty kept", int'(empty_ofs), 'h2A5);
    endtask

    task automatic t_partial_serial();
        ser_bits(10'h3FF, 3);
        partial_reset();
        ser_bits(10'h155, OFS_W);
        chk("R7 partial shift discarded", int'(empty_ofs), 'h155);
        chk("R7 full kept, serial path kept R2", int'(full_ofs), 'h0F3);
        readback("R6 readback on serial path", 'h155);
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_parallel_defaults();
        t_readback();
        t_idle_strobes();
        t_partial_parallel();
        t_serial();
        t_partial_serial();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule